// File: doc/BRIEF.md
# Synthesizer Divider Programming Front End

This block is the control-register front end of an integer-N frequency synthesizer. It collects a 20-bit divider setting and an 8-bit mode word, and it presents the reference divider value (6 bits), the main divider value (9 bits), the swallow count (4 bits) and an active-low prescaler enable to the counters. It also presents the decoded mode flags. A setting can arrive by one of three routes. The serial route uses a data clock, a data line and write strobes. The parallel route uses an 8-bit bus with three section strobes. The direct route ties values straight to input pins.

There are two copies of the divider word, a primary and a secondary, so that software can stage the next channel while the current one is in use. A select input chooses which copy feeds the counters. The counters take a new value only on a load-boundary pulse, or on every cycle while continuous load is enabled in the mode word. The mode word is itself double-buffered in serial operation: shifting touches only a staging register, and the staged value moves into the working register when the mode strobe falls.

All external strobes are registered once by the system clock. Edges are detected by comparing each sample with the one before it, so every register action takes place one clock after the strobe is first sampled.

Top module: `synth_prog_if`

## Requirements
- R1: The interface is chosen by two inputs. `mode_direct`=1 selects direct. `mode_direct`=0 with `mode_serial`=1 selects serial. Both at 0 select parallel. Strobes that belong to a route other than the selected one change no register.
- R2: In serial mode, while `ser_wr` and `enh_wr` are both low, each rising edge of `ser_clk` shifts `ser_data` into the primary word. After 20 shifts, the first bit taken sits in word bit 19. The word bit layout from 19 down to 0 is R[5], R[4], M[8], M[7], prescaler enable (active low), M[6:0], R[3:0], A[3:0].
- R3: A rising edge of `ser_wr` (serial mode) or of `hop_wr` (serial or parallel mode) copies the primary word into the secondary word. Without such an edge the secondary word is unchanged.
- R4: In parallel mode, a rising edge on a section strobe latches the bus into the primary word. `wr_mlow` loads {prescaler enable, M[6:0]} from bus[7:0]. `wr_mhigh` loads {R[5:4], M[8:7]} from bus[3:0]. `wr_ra` loads {R[3:0], A[3:0]} from bus[7:0].
- R5: When `load_tick` is high at a clock edge, the counter outputs take the primary word if `src_sel`=1, or the secondary word if `src_sel`=0. Otherwise they hold, even when `src_sel` or the stored words change.
- R6: In direct mode, the load value is taken from `dir_pre_n`, `dir_m`, `dir_r` and `dir_a`, with R[5:4] and M[8:7] forced to 0. Direct mode leaves the primary word untouched.
- R7: In serial mode, while `enh_wr` is high and `ser_wr` is low, `ser_clk` rising edges shift bits into a mode staging register. The working mode word takes the staged value only on the falling edge of `enh_wr`.
- R8: In parallel mode, the rising edge of `enh_wr` latches the bus into the working mode word. bus[7] is mode bit 0.
- R9: The mode flags are all 0 while `enh_en_n` is high. While it is low, the flags follow the working mode word, with bit 0 being the first serial bit, or bus[7]. Bit 3 drives `pwr_down`. Bit 4 drives `cnt_load_cont`. Bit 5 drives `dbg_msel`. Bit 6 drives `dbg_prescale`. Bit 7 drives `mon_off`. Bits 0 to 2 have no output.
- R10: While `cnt_load_cont` is 1, the counter outputs take the selected source at every clock edge, without `load_tick`.
- R11: After reset, all counter outputs and mode flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_direct | input | 1 | 1 selects the direct pin route |
| mode_serial | input | 1 | With mode_direct low: 1 serial, 0 parallel |
| ser_clk | input | 1 | Serial data clock (sampled) |
| ser_data | input | 1 | Serial data, first bit is the word MSB |
| ser_wr | input | 1 | Serial word strobe; rising edge commits primary to secondary |
| enh_wr | input | 1 | Mode-word strobe / shift steering |
| hop_wr | input | 1 | Copies primary to secondary on its rising edge |
| par_bus | input | 8 | Parallel data bus |
| wr_mlow | input | 1 | Section strobe: prescaler enable and M[6:0] |
| wr_mhigh | input | 1 | Section strobe: R[5:4] and M[8:7] |
| wr_ra | input | 1 | Section strobe: R[3:0] and A[3:0] |
| src_sel | input | 1 | 1 primary, 0 secondary as counter source |
| load_tick | input | 1 | Counter-load boundary pulse |
| enh_en_n | input | 1 | Active-low enable for the mode flags |
| dir_pre_n | input | 1 | Direct prescaler enable, active low |
| dir_m | input | 7 | Direct M[6:0] |
| dir_r | input | 4 | Direct R[3:0] |
| dir_a | input | 4 | Direct A[3:0] |
| r_val | output | 6 | Applied reference divider value |
| m_val | output | 9 | Applied main divider value |
| a_val | output | 4 | Applied swallow count |
| pre_en_n | output | 1 | Applied prescaler enable, active low |
| pwr_down | output | 1 | Power-down flag |
| cnt_load_cont | output | 1 | Continuous counter load flag |
| dbg_msel | output | 1 | Route modulus select to debug output |
| dbg_prescale | output | 1 | Route raw prescaler output to debug output |
| mon_off | output | 1 | Disable divider monitor outputs |

## Verification
The hardest case to reach from the ports is the one where the staged and live copies differ at the moment the source changes. Either the primary word has been rewritten since the last commit, or the mode staging register holds bits that have not been captured yet. In that case, only the right strobe edge or load pulse may expose the new value. The stimulus gets there by loading a fresh primary word without committing it, then flipping `src_sel` and checking the outputs both before and after a load pulse. It also shifts mode bits, checks the flags before the strobe falls, and checks them again after the fall. Constrained-random operation sequences mix serial, parallel and direct loads, hops and source flips between load pulses. Directed cases cover continuous load, cross-route strobes and the forced-zero fields of direct mode.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
    localparam int WORD_W = 20;
    localparam int ENH_W  = 8;
    localparam int BUS_W  = 8;
    localparam int R_W    = 6;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int MLO_W  = 7;
    localparam int RLO_W  = 4;
    localparam int NSEC   = 3;

    // strobe slots in the sampler vector
    localparam int ST_SCLK = 0;
    localparam int ST_SWR  = 1;
    localparam int ST_EWR  = 2;
    localparam int ST_HOP  = 3;
    localparam int ST_WML  = 4;
    localparam int ST_WMH  = 5;
    localparam int ST_WRA  = 6;
    localparam int NSTB    = 7;

    // mode-word bit n (n = order of arrival) lives at vector index ENH_W-1-n
    localparam int EB_PWR  = ENH_W - 1 - 3;
    localparam int EB_CONT = ENH_W - 1 - 4;
    localparam int EB_MSEL = ENH_W - 1 - 5;
    localparam int EB_PRE  = ENH_W - 1 - 6;
    localparam int EB_MON  = ENH_W - 1 - 7;

    typedef struct packed {
        logic [R_W-RLO_W-1:0] r_hi;
        logic [M_W-MLO_W-1:0] m_hi;
        logic                 pre_n;
        logic [MLO_W-1:0]     m_lo;
        logic [RLO_W-1:0]     r_lo;
        logic [A_W-1:0]       a;
    } cword_t;

    typedef struct packed {
        logic pwr_down;
        logic cnt_cont;
        logic dbg_msel;
        logic dbg_pre;
        logic mon_off;
    } enh_ctl_t;

    typedef enum logic [1:0] {
        IF_PAR = 2'd0,
        IF_SER = 2'd1,
        IF_DIR = 2'd2
    } if_mode_t;

    function automatic if_mode_t pick_mode(input logic dir, input logic ser);
        if (dir)      return IF_DIR;
        else if (ser) return IF_SER;
        else          return IF_PAR;
    endfunction

    function automatic enh_ctl_t enh_decode(input logic [ENH_W-1:0] b, input logic en_n);
        enh_ctl_t c;
        c = '0;
        if (!en_n) begin
            c.pwr_down = b[EB_PWR];
            c.cnt_cont = b[EB_CONT];
            c.dbg_msel = b[EB_MSEL];
            c.dbg_pre  = b[EB_PRE];
            c.mon_off  = b[EB_MON];
        end
        return c;
    endfunction
endpackage

// File: rtl/synprog_sampler.sv
module synprog_sampler #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);
    logic [N-1:0] s_q;
    logic [N-1:0] p_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q[i] <= 1'b0;
                p_q[i] <= 1'b0;
            end else begin
                s_q[i] <= raw[i];
                p_q[i] <= s_q[i];
            end
        end
    end

    assign lvl = s_q;
    assign prv = p_q;
endmodule

// File: rtl/synprog_words.sv
module synprog_words
    import synprog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic [NSEC-1:0]  sec_wr,
    input  logic [BUS_W-1:0] bus,
    input  logic             copy,
    output cword_t           prim,
    output cword_t           sec
);
    cword_t prim_q;
    cword_t sec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            sec_q  <= '0;
        end else begin
            if (shift_en)
                prim_q <= cword_t'({prim_q[WORD_W-2:0], shift_bit});
            if (sec_wr[0])
                {prim_q.pre_n, prim_q.m_lo} <= bus;
            if (sec_wr[1])
                {prim_q.r_hi, prim_q.m_hi} <= bus[3:0];
            if (sec_wr[2])
                {prim_q.r_lo, prim_q.a} <= bus;
            if (copy)
                sec_q <= prim_q;
        end
    end

    assign prim = prim_q;
    assign sec  = sec_q;
endmodule

// File: rtl/synprog_enh.sv
module synprog_enh
    import synprog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             cap_ser,
    input  logic             cap_par,
    input  logic [BUS_W-1:0] bus,
    output logic [ENH_W-1:0] work
);
    logic [ENH_W-1:0] stage_q;
    logic [ENH_W-1:0] work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            work_q  <= '0;
        end else begin
            if (shift_en)
                stage_q <= {stage_q[ENH_W-2:0], shift_bit};
            if (cap_ser)
                work_q <= stage_q;
            else if (cap_par)
                work_q <= bus;
        end
    end

    assign work = work_q;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synprog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_direct,
    input  logic             mode_serial,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_wr,
    input  logic             enh_wr,
    input  logic             hop_wr,
    input  logic [BUS_W-1:0] par_bus,
    input  logic             wr_mlow,
    input  logic             wr_mhigh,
    input  logic             wr_ra,
    input  logic             src_sel,
    input  logic             load_tick,
    input  logic             enh_en_n,
    input  logic             dir_pre_n,
    input  logic [MLO_W-1:0] dir_m,
    input  logic [RLO_W-1:0] dir_r,
    input  logic [A_W-1:0]   dir_a,
    output logic [R_W-1:0]   r_val,
    output logic [M_W-1:0]   m_val,
    output logic [A_W-1:0]   a_val,
    output logic             pre_en_n,
    output logic             pwr_down,
    output logic             cnt_load_cont,
    output logic             dbg_msel,
    output logic             dbg_prescale,
    output logic             mon_off
);
    logic [NSTB-1:0]  stb_raw, stb_lvl, stb_prv, stb_rise;
    logic             ewr_fall;
    logic             sdat_q;
    logic [BUS_W-1:0] bus_q;
    if_mode_t         mode_q;
    logic             is_ser, is_par, is_dir;
    logic             word_shift, enh_shift, copy_ev, cap_ser, cap_par, enh_cap, upd;
    logic [NSEC-1:0]  sec_wr;
    cword_t           prim_q, sec_q, dir_word, src_word, applied_q;
    logic [ENH_W-1:0] enh_q;
    enh_ctl_t         ctl;

    assign stb_raw[ST_SCLK] = ser_clk;
    assign stb_raw[ST_SWR]  = ser_wr;
    assign stb_raw[ST_EWR]  = enh_wr;
    assign stb_raw[ST_HOP]  = hop_wr;
    assign stb_raw[ST_WML]  = wr_mlow;
    assign stb_raw[ST_WMH]  = wr_mhigh;
    assign stb_raw[ST_WRA]  = wr_ra;

    synprog_sampler #(.N(NSTB)) u_smp (
        .clk (clk),
        .rst (rst),
        .raw (stb_raw),
        .lvl (stb_lvl),
        .prv (stb_prv)
    );

    // data and mode inputs share the strobe sampling stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sdat_q <= 1'b0;
            bus_q  <= '0;
            mode_q <= IF_PAR;
        end else begin
            sdat_q <= ser_data;
            bus_q  <= par_bus;
            mode_q <= pick_mode(mode_direct, mode_serial);
        end
    end

    assign stb_rise = stb_lvl & ~stb_prv;
    assign ewr_fall = ~stb_lvl[ST_EWR] & stb_prv[ST_EWR];

    assign is_ser = (mode_q == IF_SER);
    assign is_par = (mode_q == IF_PAR);
    assign is_dir = (mode_q == IF_DIR);

    assign word_shift = is_ser & stb_rise[ST_SCLK] & ~stb_lvl[ST_SWR] & ~stb_lvl[ST_EWR];
    assign enh_shift  = is_ser & stb_rise[ST_SCLK] & ~stb_lvl[ST_SWR] &  stb_lvl[ST_EWR];
    assign copy_ev    = (is_ser & stb_rise[ST_SWR]) | ((is_ser | is_par) & stb_rise[ST_HOP]);
    assign sec_wr     = {NSEC{is_par}} & {stb_rise[ST_WRA], stb_rise[ST_WMH], stb_rise[ST_WML]};
    assign cap_ser    = is_ser & ewr_fall;
    assign cap_par    = is_par & stb_rise[ST_EWR];
    assign enh_cap    = cap_ser | cap_par;

    synprog_words u_words (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (word_shift),
        .shift_bit (sdat_q),
        .sec_wr    (sec_wr),
        .bus       (bus_q),
        .copy      (copy_ev),
        .prim      (prim_q),
        .sec       (sec_q)
    );

    synprog_enh u_enh (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (enh_shift),
        .shift_bit (sdat_q),
        .cap_ser   (cap_ser),
        .cap_par   (cap_par),
        .bus       (bus_q),
        .work      (enh_q)
    );

    always_comb begin
        dir_word       = '0;
        dir_word.pre_n = dir_pre_n;
        dir_word.m_lo  = dir_m;
        dir_word.r_lo  = dir_r;
        dir_word.a     = dir_a;
        if (is_dir)       src_word = dir_word;
        else if (src_sel) src_word = prim_q;
        else              src_word = sec_q;
    end

    assign ctl = enh_decode(enh_q, enh_en_n);
    assign upd = load_tick | ctl.cnt_cont;

    always_ff @(posedge clk) begin
        if (rst)      applied_q <= '0;
        else if (upd) applied_q <= src_word;
    end

    assign r_val         = {applied_q.r_hi, applied_q.r_lo};
    assign m_val         = {applied_q.m_hi, applied_q.m_lo};
    assign a_val         = applied_q.a;
    assign pre_en_n      = applied_q.pre_n;
    assign pwr_down      = ctl.pwr_down;
    assign cnt_load_cont = ctl.cnt_cont;
    assign dbg_msel      = ctl.dbg_msel;
    assign dbg_prescale  = ctl.dbg_pre;
    assign mon_off       = ctl.mon_off;
endmodule

// File: rtl/synprog_checks.sv
module synprog_checks
    import synprog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             is_dir,
    input logic             upd,
    input logic             copy_ev,
    input logic             enh_cap,
    input logic [WORD_W-1:0] prim,
    input logic [WORD_W-1:0] sec,
    input logic [ENH_W-1:0] enh,
    input logic [R_W-1:0]   r_val,
    input logic [M_W-1:0]   m_val,
    input logic [A_W-1:0]   a_val,
    input logic             pre_en_n
);
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable({r_val, m_val, a_val, pre_en_n}));                    // R5

    AST_DIRECT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (upd && is_dir) |=> (r_val[R_W-1:RLO_W] == '0 && m_val[M_W-1:MLO_W] == '0)); // R6

    AST_DIRECT_PRIM_KEPT: assert property (@(posedge clk) disable iff (rst)
        is_dir |=> $stable(prim));                                              // R1

    AST_SEC_ONLY_ON_COPY: assert property (@(posedge clk) disable iff (rst)
        !copy_ev |=> $stable(sec));                                             // R3

    AST_ENH_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !enh_cap |=> $stable(enh));                                             // R7
endmodule

bind synth_prog_if synprog_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .is_dir   (is_dir),
    .upd      (upd),
    .copy_ev  (copy_ev),
    .enh_cap  (enh_cap),
    .prim     (prim_q),
    .sec      (sec_q),
    .enh      (enh_q),
    .r_val    (r_val),
    .m_val    (m_val),
    .a_val    (a_val),
    .pre_en_n (pre_en_n)
);

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
    localparam int CLK_P = 10;
    localparam int WDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_direct = 1'b0, mode_serial = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_wr = 1'b0, enh_wr = 1'b0, hop_wr = 1'b0;
    logic [7:0] par_bus = '0;
    logic wr_mlow = 1'b0, wr_mhigh = 1'b0, wr_ra = 1'b0;
    logic src_sel = 1'b0, load_tick = 1'b0, enh_en_n = 1'b1;
    logic dir_pre_n = 1'b0;
    logic [6:0] dir_m = '0;
    logic [3:0] dir_r = '0, dir_a = '0;
    logic [5:0] r_val;
    logic [8:0] m_val;
    logic [3:0] a_val;
    logic pre_en_n, pwr_down, cnt_load_cont, dbg_msel, dbg_prescale, mon_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [19:0] exp_prim = '0, exp_sec = '0, exp_app = '0;
    logic [7:0]  exp_enh = '0;
    int          cur_mode = 0; // 0 parallel, 1 serial, 2 direct

    always #(CLK_P/2) clk = ~clk;

    synth_prog_if uut (
        .clk(clk), .rst(rst), .mode_direct(mode_direct), .mode_serial(mode_serial),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_wr(ser_wr), .enh_wr(enh_wr),
        .hop_wr(hop_wr), .par_bus(par_bus), .wr_mlow(wr_mlow), .wr_mhigh(wr_mhigh),
        .wr_ra(wr_ra), .src_sel(src_sel), .load_tick(load_tick), .enh_en_n(enh_en_n),
        .dir_pre_n(dir_pre_n), .dir_m(dir_m), .dir_r(dir_r), .dir_a(dir_a),
        .r_val(r_val), .m_val(m_val), .a_val(a_val), .pre_en_n(pre_en_n),
        .pwr_down(pwr_down), .cnt_load_cont(cnt_load_cont), .dbg_msel(dbg_msel),
        .dbg_prescale(dbg_prescale), .mon_off(mon_off)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // word layout 19..0: R5 R4 M8 M7 PRE M6..M0 R3..R0 A3..A0
    function automatic logic [19:0] outs_of(input logic [19:0] w);
        return {w[19:18], w[7:4], w[17:16], w[14:8], w[3:0], w[15]};
    endfunction

    function automatic logic [19:0] dir_word();
        return {4'b0000, dir_pre_n, dir_m, dir_r, dir_a};
    endfunction

    function automatic logic [19:0] cur_src();
        if (cur_mode == 2) return dir_word();
        return src_sel ? exp_prim : exp_sec;
    endfunction

    function automatic logic [4:0] flags_of(input logic [7:0] b, input logic en_n);
        if (en_n) return 5'b0;
        return {b[4], b[3], b[2], b[1], b[0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_ctr(input string req, input string what);
        check(req, what, 32'({r_val, m_val, a_val, pre_en_n}), 32'(outs_of(exp_app)));
    endtask

    task automatic chk_flags(input string req, input string what);
        check(req, what,
              32'({pwr_down, cnt_load_cont, dbg_msel, dbg_prescale, mon_off}),
              32'(flags_of(exp_enh, enh_en_n)));
    endtask

    task automatic set_mode(input int m);
        cur_mode    = m;
        mode_direct = (m == 2);
        mode_serial = (m == 1);
        step(2);
    endtask

    task automatic tick();
        load_tick = 1'b1;
        step(1);
        load_tick = 1'b0;
        exp_app = cur_src();
        step(1);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b;
        step(1);
        ser_clk = 1'b1;
        step(2);
        ser_clk = 1'b0;
        step(1);
    endtask

    task automatic ser_word(input logic [19:0] w);
        for (int i = 19; i >= 0; i--) shift_bit(w[i]);
        if (cur_mode == 1) exp_prim = w;
    endtask

    task automatic pulse_swr();
        ser_wr = 1'b1; step(2); ser_wr = 1'b0; step(2);
        if (cur_mode == 1) exp_sec = exp_prim;
    endtask

    task automatic pulse_hop();
        hop_wr = 1'b1; step(2); hop_wr = 1'b0; step(2);
        if (cur_mode != 2) exp_sec = exp_prim;
    endtask

    task automatic ser_enh_shift(input logic [7:0] b);
        enh_wr = 1'b1;
        step(2);
        for (int i = 7; i >= 0; i--) shift_bit(b[i]);
    endtask

    task automatic ser_enh_close(input logic [7:0] b);
        enh_wr = 1'b0;
        step(2);
        if (cur_mode == 1) exp_enh = b;
    endtask

    // which: 0 mlow, 1 mhigh, 2 ra, 3 mode word
    task automatic par_raw(input int which, input logic [7:0] v);
        par_bus = v;
        step(1);
        case (which)
            0: wr_mlow = 1'b1;
            1: wr_mhigh = 1'b1;
            2: wr_ra = 1'b1;
            default: enh_wr = 1'b1;
        endcase
        step(2);
        wr_mlow = 1'b0; wr_mhigh = 1'b0; wr_ra = 1'b0; enh_wr = 1'b0;
        step(2);
    endtask

    task automatic par_wr(input int which, input logic [7:0] v);
        par_raw(which, v);
        if (cur_mode == 0) begin
            case (which)
                0: exp_prim[15:8] = v;
                1: exp_prim[19:16] = v[3:0];
                2: exp_prim[7:0] = v;
                default: exp_enh = v;
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        logic [19:0] w;
        logic [7:0]  v;
        seed = $urandom(32'h5EED_0042);
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        check("R11", "counters after reset", 32'({r_val, m_val, a_val, pre_en_n}), 32'h0);
        enh_en_n = 1'b0;
        step(1);
        check("R11", "flags after reset", 32'({pwr_down, cnt_load_cont, dbg_msel, dbg_prescale, mon_off}), 32'h0);

        // R2 serial shift, MSB first, layout
        set_mode(1);
        src_sel = 1'b1;
        ser_word(20'hC5A3B);
        chk_ctr("R5", "held before load tick");
        tick();
        chk_ctr("R2", "serial word via primary");
        check("R2", "R[5:4] from first bits", 32'(r_val[5:4]), 32'h3);

        // R3 commit by serial strobe, R5 secondary select
        pulse_swr();
        ser_word(20'h1234F);
        src_sel = 1'b0;
        step(1);
        chk_ctr("R5", "source flip without tick holds");
        tick();
        chk_ctr("R3", "secondary holds committed word");
        src_sel = 1'b1;
        tick();
        chk_ctr("R5", "primary selected");

        // R7 serial mode word double buffering
        ser_enh_shift(8'b0001_0110);
        chk_flags("R7", "flags unchanged while shifting");
        ser_enh_close(8'b0001_0110);
        chk_flags("R9", "flags after capture");
        enh_en_n = 1'b1;
        step(1);
        chk_flags("R9", "flags gated off by enable");
        enh_en_n = 1'b0;
        step(1);

        // R1 parallel strobes ignored in serial mode
        w = exp_app;
        par_raw(2, 8'hFF);
        par_raw(0, 8'hFF);
        tick();
        check("R1", "parallel strobes ignored in serial", 32'(outs_of(w)), 32'(outs_of(exp_app)));
        chk_ctr("R1", "primary untouched by parallel strobes");

        // R4 parallel sections, R3 hop
        set_mode(0);
        par_wr(0, 8'hA7);
        par_wr(1, 8'hF9);
        par_wr(2, 8'h5C);
        tick();
        chk_ctr("R4", "three section writes");
        check("R4", "M[8:7] from bus[1:0]", 32'(m_val[8:7]), 32'h1);
        pulse_hop();
        src_sel = 1'b0;
        tick();
        chk_ctr("R3", "hop copies primary");
        par_wr(3, 8'b0000_1101);
        chk_flags("R8", "parallel mode word latch");
        // serial clocks ignored in parallel mode
        ser_word(20'hFFFFF);
        src_sel = 1'b1;
        tick();
        chk_ctr("R1", "serial clocks ignored in parallel");

        // R6 direct mode
        set_mode(2);
        dir_pre_n = 1'b1; dir_m = 7'h6B; dir_r = 4'hE; dir_a = 4'h9;
        tick();
        chk_ctr("R6", "direct pins");
        check("R6", "forced-zero high fields", 32'({r_val[5:4], m_val[8:7]}), 32'h0);
        pulse_hop();
        set_mode(0);
        src_sel = 1'b0;
        tick();
        chk_ctr("R6", "hop ignored in direct, secondary kept");
        src_sel = 1'b1;
        tick();
        chk_ctr("R6", "primary kept across direct mode");

        // R10 continuous load
        par_wr(3, 8'b0000_1000);
        check("R10", "continuous flag", 32'(cnt_load_cont), 32'h1);
        par_wr(2, 8'h3D);
        exp_app = cur_src();
        chk_ctr("R10", "follows primary without tick");
        src_sel = 1'b0;
        step(2);
        exp_app = cur_src();
        chk_ctr("R10", "follows source flip without tick");
        par_wr(3, 8'h00);
        exp_app = cur_src();
        par_wr(2, 8'h77);
        chk_ctr("R5", "holds after continuous load cleared");

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom_range(0, 7);
            w  = 20'($urandom);
            v  = 8'($urandom);
            case (op)
                0: begin set_mode(1); ser_word(w); pulse_swr(); end
                1: begin set_mode(1); ser_word(w); end
                2: begin set_mode(0); par_wr($urandom_range(0, 2), v); end
                3: begin set_mode($urandom_range(0, 1)); pulse_hop(); end
                4: begin src_sel = ~src_sel; step(1); chk_ctr("R5", "random flip holds"); end
                5: begin set_mode(2); dir_pre_n = v[0]; dir_m = w[6:0]; dir_r = w[10:7]; dir_a = w[14:11]; step(1); end
                6: begin
                    set_mode(1);
                    v = v & 8'hF7;
                    ser_enh_shift(v);
                    ser_enh_close(v);
                    enh_en_n = 1'($urandom);
                    step(1);
                    chk_flags("R9", "random serial mode word");
                end
                default: begin
                    set_mode(0);
                    v = v & 8'hF7;
                    par_wr(3, v);
                    chk_flags("R8", "random parallel mode word");
                end
            endcase
            tick();
            chk_ctr("R5", "random load");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule